// File: doc/BRIEF.md
# Stream FIFO Fill-Level Interrupt Aggregator

This block sits beside a bank of up to eight receive and eight transmit stream FIFOs. It watches each FIFO's fill count and notices the moment a FIFO reaches half of its depth. That moment is recorded in a per-FIFO sticky flag, and the block raises a one-cycle interrupt pulse to the CPU. There is one pulse output for the receive side and one for the transmit side, so a single request line covers all links of a direction.

A service routine reads one status word to find which FIFOs fired, then clears those flags by writing ones. A FIFO whose flag is still set cannot pulse again, so no event is reported twice. The outputs are single-cycle events and never a held level, so a CPU that nests interrupts does not take the same request over and over. The half-full point follows from the build-time depth parameter and cannot be changed at runtime.

Top module: `fifo_level_irq_agg`

## Requirements
- R1: A FIFO is at or above its threshold when its fill count is at least DEPTH/2. With DEPTH=16, a count of 7 is below the threshold and a count of 8 is at it.
- R2: Only a transition from below the threshold to at-or-above it is an event. A FIFO that stays above the threshold produces no new event, even after its flag has been cleared.
- R3: The status word has receive FIFO i in bit i and transmit FIFO j in bit 8+j. Bits of links that are not built, and bits 31:16, read as 0. `bus_rdata` shows the status word combinationally while `bus_sel` is 1 and reads 0 otherwise.
- R4: A write (`bus_sel`=1, `bus_we`=1) clears every flag whose `bus_wdata` bit is 1. Flags under 0 bits are left unchanged.
- R5: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: An event on a FIFO whose flag is clear sets that flag and pulses `irq_rx` (receive FIFO) or `irq_tx` (transmit FIFO) high for exactly one cycle. The pulse comes in the cycle after the clock edge at which the new count is sampled, together with the flag.
- R7: An event on a FIFO whose flag is already set causes no pulse.
- R8: Events on several FIFOs of one direction in the same cycle give a single one-cycle pulse and set every flag involved.
- R9: A synchronous reset clears all flags, edge-detect state and pulses. A FIFO already at or above its threshold when reset is released counts as an event on the first clock after reset.
- R10: The receive and transmit sides work independently. Events on both sides in the same cycle pulse both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | NUM_RX*CNT_W | Receive FIFO fill counts, FIFO i at [i*CNT_W +: CNT_W] |
| tx_level | input | NUM_TX*CNT_W | Transmit FIFO fill counts, FIFO j at [j*CNT_W +: CNT_W] |
| bus_sel | input | 1 | Status register selected |
| bus_we | input | 1 | Write strobe; a write clears flags |
| bus_wdata | input | 32 | Write-one-to-clear mask |
| bus_rdata | output | 32 | Status word |
| irq_rx | output | 1 | Receive-side interrupt pulse |
| irq_tx | output | 1 | Transmit-side interrupt pulse |

## Verification
Two cases are hard to reach from the ports. One is a FIFO crossing its threshold in the very cycle its flag is cleared. The other is a FIFO crossing again while its flag is still set. Both need the threshold crossing and the bus write placed on exact cycles. The bench drives the fill counts directly, so it can drop a count below the threshold and raise it back in the same cycle as a write. A behavioural model checks every clock, and a long random phase mixes crossings, reads and clears across all links.

// File: rtl/flirq_pkg.sv
package flirq_pkg;
   localparam int unsigned FLIRQ_MAX_LINKS = 8;
   localparam int unsigned FLIRQ_BUS_W     = 32;
   localparam int unsigned FLIRQ_TX_BASE   = 8;
   localparam int unsigned FLIRQ_FLAGS_W   = 2 * FLIRQ_MAX_LINKS;
endpackage

// File: rtl/flirq_lane.sv
module flirq_lane #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] level,
   input  logic             clr,
   output logic             flag,
   output logic             req
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   logic hf;
   logic hf_q;
   logic rise;
   logic unused_lvl;

   assign unused_lvl = ^level;

   // count width chooses how the half-full test is decoded
   generate
      if (CNT_W == PTR_W + 1) begin : g_full_count
         assign hf = |level[CNT_W-1 -: 2];
      end else begin : g_wrap_count
         assign hf = level[CNT_W-1];
      end
   endgenerate

   assign rise = hf & ~hf_q;
   assign req  = rise & ~flag;

   always_ff @(posedge clk) begin
      if (rst) begin
         hf_q <= 1'b0;
         flag <= 1'b0;
      end else begin
         hf_q <= hf;
         if (rise)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
      end
   end

   // R2, R5: a threshold crossing leaves the flag set, clear or not
   assert_rise_sets_R5: assert property (@(posedge clk) disable iff (rst)
      (hf && !hf_q) |=> flag);
   assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr) |=> flag);
   assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
      (flag && clr && !(hf && !hf_q)) |=> !flag);
endmodule

// File: rtl/flirq_group.sv
module flirq_group #(
   parameter int unsigned NUM   = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM*CNT_W-1:0] levels,
   input  logic [NUM-1:0]       clr,
   output logic [NUM-1:0]       flags,
   output logic                 irq
);
   logic [NUM-1:0] req;

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_lane
         flirq_lane #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .level (levels[i*CNT_W +: CNT_W]),
            .clr   (clr[i]),
            .flag  (flags[i]),
            .req   (req[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         irq <= 1'b0;
      else
         irq <= |req;
   end

   // R6: every pulse coincides with at least one newly set flag
   assert_pulse_marks_flag_R6: assert property (@(posedge clk) disable iff (rst)
      irq |-> ((flags & ~$past(flags)) != '0));
   // R7: with every flag already set the line stays quiet
   assert_quiet_when_set_R7: assert property (@(posedge clk) disable iff (rst)
      (&flags) |=> !irq);
endmodule

// File: rtl/fifo_level_irq_agg.sv
module fifo_level_irq_agg
   import flirq_pkg::*;
#(
   parameter int unsigned NUM_RX         = 8,
   parameter int unsigned NUM_TX         = 8,
   parameter int unsigned DEPTH          = 16,
   parameter bit          COUNT_HAS_FULL = 1'b1,
   localparam int unsigned PTR_W         = $clog2(DEPTH),
   localparam int unsigned CNT_W         = PTR_W + (COUNT_HAS_FULL ? 1 : 0)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_RX*CNT_W-1:0] rx_level,
   input  logic [NUM_TX*CNT_W-1:0] tx_level,
   input  logic                    bus_sel,
   input  logic                    bus_we,
   input  logic [FLIRQ_BUS_W-1:0]  bus_wdata,
   output logic [FLIRQ_BUS_W-1:0]  bus_rdata,
   output logic                    irq_rx,
   output logic                    irq_tx
);
   generate
      if (NUM_RX < 1 || NUM_RX > FLIRQ_MAX_LINKS) begin : g_bad_rx
         $error("NUM_RX must lie in 1..8");
      end
      if (NUM_TX < 1 || NUM_TX > FLIRQ_MAX_LINKS) begin : g_bad_tx
         $error("NUM_TX must lie in 1..8");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [FLIRQ_FLAGS_W-1:0] clr_mask;
   logic [NUM_RX-1:0]        rx_flags;
   logic [NUM_TX-1:0]        tx_flags;
   logic [FLIRQ_BUS_W-1:0]   status;
   logic                     unused_wdata;

   assign clr_mask     = (bus_sel && bus_we) ? bus_wdata[FLIRQ_FLAGS_W-1:0] : '0;
   assign unused_wdata = ^{bus_wdata[FLIRQ_BUS_W-1:FLIRQ_FLAGS_W], clr_mask};

   flirq_group #(.NUM(NUM_RX), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk    (clk),
      .rst    (rst),
      .levels (rx_level),
      .clr    (clr_mask[NUM_RX-1:0]),
      .flags  (rx_flags),
      .irq    (irq_rx)
   );

   flirq_group #(.NUM(NUM_TX), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk    (clk),
      .rst    (rst),
      .levels (tx_level),
      .clr    (clr_mask[FLIRQ_TX_BASE +: NUM_TX]),
      .flags  (tx_flags),
      .irq    (irq_tx)
   );

   always_comb begin
      status = '0;
      status[NUM_RX-1:0]              = rx_flags;
      status[FLIRQ_TX_BASE +: NUM_TX] = tx_flags;
   end

   assign bus_rdata = bus_sel ? status : '0;

   // R3: outside a selected access the bus returns zero
   assert_idle_read_R3: assert property (@(posedge clk) disable iff (rst)
      !bus_sel |-> (bus_rdata == '0));
   // R9: the cycle after reset carries no pulse
   assert_reset_quiet_R9: assert property (@(posedge clk)
      $past(rst) |-> (!irq_rx && !irq_tx));
endmodule

// File: tb/fifo_level_irq_agg_bench.sv
`timescale 1ns/1ps
module fifo_level_irq_agg_bench;
   localparam int NRX   = 8;
   localparam int NTX   = 5;
   localparam int DEPTH = 16;
   localparam int CW    = 5;
   localparam int HALF  = DEPTH / 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [CW-1:0] rxl [8];
   logic [CW-1:0] txl [8];
   logic [NRX*CW-1:0] rx_level;
   logic [NTX*CW-1:0] tx_level;
   logic bus_sel = 1'b0;
   logic bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq_rx, irq_tx;

   int checks = 0;
   int errors = 0;
   string tag = "R9";
   bit done = 1'b0;

   bit m_flag [16];
   bit m_hfq  [16];
   bit m_irx, m_itx;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NRX; i++) rx_level[i*CW +: CW] = rxl[i];
      for (int j = 0; j < NTX; j++) tx_level[j*CW +: CW] = txl[j];
   end

   fifo_level_irq_agg #(.NUM_RX(NRX), .NUM_TX(NTX), .DEPTH(DEPTH)) u_fifo_level_irq_agg (
      .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx));

   task automatic model_tick();
      bit nrx, ntx, impl, hf, ev, clr;
      int lvl;
      nrx = 0; ntx = 0;
      for (int k = 0; k < 16; k++) begin
         if (rst) begin
            m_flag[k] = 0; m_hfq[k] = 0;
         end else begin
            impl = (k < 8) ? (k < NRX) : ((k - 8) < NTX);
            if (impl) begin
               lvl = (k < 8) ? int'(rxl[k]) : int'(txl[k-8]);
               hf  = (lvl >= HALF);
               ev  = hf && !m_hfq[k];
               clr = bus_sel && bus_we && bus_wdata[k];
               if (ev && !m_flag[k]) begin
                  if (k < 8) nrx = 1; else ntx = 1;
               end
               if (ev) m_flag[k] = 1;
               else if (clr) m_flag[k] = 0;
               m_hfq[k] = hf;
            end
         end
      end
      m_irx = nrx; m_itx = ntx;
   endtask

   task automatic check1(string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   always begin
      logic [31:0] exp_rd;
      @(posedge clk);
      model_tick();
      #1;
      if (!done) begin
         exp_rd = '0;
         for (int k = 0; k < 16; k++) exp_rd[k] = m_flag[k];
         if (!bus_sel) exp_rd = '0;
         check1("irq_rx", {31'b0, irq_rx}, {31'b0, m_irx});
         check1("irq_tx", {31'b0, irq_tx}, {31'b0, m_itx});
         check1("bus_rdata", bus_rdata, exp_rd);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [31:0] d);
      bus_sel = 1; bus_we = 1; bus_wdata = d;
      cyc(1);
      bus_we = 0; bus_wdata = '0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired in phase %s", tag);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin rxl[i] = '0; txl[i] = '0; end
      // R9: counts high during reset must not pulse before release
      rxl[5] = 5'd12;
      cyc(3);
      rst = 0;
      bus_sel = 1;
      cyc(3);
      rxl[5] = 0;
      wr(32'h0000_0020);
      cyc(2);

      tag = "R1";
      rxl[0] = 5'd7; cyc(3);
      rxl[0] = 5'd8; cyc(3);

      tag = "R6";
      txl[2] = 5'd16; cyc(3);
      rxl[1] = 5'd15; cyc(1); bus_sel = 0; cyc(2); bus_sel = 1;

      tag = "R7";
      rxl[0] = 5'd0; cyc(2);
      rxl[0] = 5'd9; cyc(3);

      tag = "R4";
      wr(32'hFFFF_0000); cyc(1);
      wr(32'h0000_0002); cyc(1);
      wr(32'h0000_0001); cyc(1);
      rxl[0] = 5'd3; cyc(1); rxl[0] = 5'd8; cyc(3);

      tag = "R2";
      wr(32'h0000_0401); cyc(4);

      tag = "R5";
      rxl[3] = 5'd10; cyc(2);
      rxl[3] = 5'd2;  cyc(1);
      rxl[3] = 5'd10; wr(32'h0000_0008); cyc(2);
      rxl[4] = 5'd0; wr(32'h0000_00FF); cyc(1);
      rxl[4] = 5'd0; cyc(1);
      rxl[4] = 5'd9; wr(32'h0000_0010); cyc(3);

      tag = "R8";
      wr(32'h0000_FFFF);
      for (int i = 0; i < 8; i++) rxl[i] = 0;
      cyc(1);
      rxl[2] = 5'd8; rxl[6] = 5'd16; rxl[7] = 5'd11; cyc(3);

      tag = "R10";
      txl[0] = 5'd9; txl[4] = 5'd8; rxl[1] = 5'd8; cyc(3);

      tag = "R3";
      wr(32'hFFFF_FFFF); bus_sel = 0; cyc(2); bus_sel = 1; cyc(2);

      tag = "R2";
      for (int n = 0; n < 1500; n++) begin
         for (int i = 0; i < NRX; i++) if ($urandom_range(3) == 0) rxl[i] = CW'($urandom_range(16));
         for (int j = 0; j < NTX; j++) if ($urandom_range(3) == 0) txl[j] = CW'($urandom_range(16));
         bus_sel   = ($urandom_range(3) != 0);
         bus_we    = ($urandom_range(7) == 0);
         bus_wdata = $urandom;
         cyc(1);
      end
      bus_we = 0;

      tag = "R9";
      rxl[0] = 5'd9; rst = 1; cyc(2); rst = 0; cyc(3);

      done = 1;
      summary();
      $finish;
   end
endmodule